// File: doc/BRIEF.md
# Fixed-Point 8x8 Forward Cosine Transform Coprocessor

This block is a bus-attached helper that turns one 8x8 tile of signed samples into 64 forward-DCT coefficients with integer arithmetic only. A host fills the tile by writing samples one at a time into a push register. It then writes the value 1 to a command register and polls a status register until the block reports ready. After that it reads the 64 coefficients back, one per read, from a pop register.

The transform is evaluated separably on a single shared multiplier. For every output position, eight row partial sums are formed first. They are then folded into one column sum, and the result is scaled by the DC-normalisation factors and a quarter. Every product is shifted right by six fraction bits before it is accumulated. The result bank is double-buffered, so the host can still read the previous tile's coefficients while the next tile is being computed.

Top module: `fdct_cop`

## Requirements
- R1: After reset, a status read returns 1 in bit 0 (ready), and a read of the pop register returns 0.
- R2: Register offsets are fixed: 0 is push (write), 1 is pop (read), 2 is command (write) and 3 is status (read, bit 0 = ready). Read data appears on `rdata` in the cycle after the read is sampled.
- R3: Push number k (counted from 0) stores the sample, shifted left by 6 and truncated to 16 bits, at row k/8 and column k%8. The push index wraps to 0 after 64 pushes and is cleared when a start is accepted.
- R4: A command write starts the transform only when its data equals 1. Any other command value leaves the block idle.
- R5: Status bit 0 reads 0 from the clock edge after an accepted start through the edge on which the last coefficient is stored. That edge lies exactly 73 x 64 = 4672 cycles after the start edge.
- R6: The cosine weight for sample index j and frequency f is 64*cos((2j+1)f*pi/16), truncated toward zero, as a signed 8-bit value.
- R7: For output (u,v), the stage-one sums are s[x] = sum over j of (img[x][j]*w(j,v)) >>> 6, and the stage-two sum is r = sum over x of (s[x]*w(x,u)) >>> 6. All accumulation is 32-bit signed.
- R8: The output is (r*K) >>> 18, truncated to 16-bit signed, where K = ((16*c(u)) >> 6)*c(v), c(0) = 45 and c(h) = 64 for h > 0.
- R9: Pop number n returns the coefficient with u = n/8 and v = n%8. The pop index wraps after 64 reads and returns to 0 on the completion edge.
- R10: A start command received while the block is busy is ignored. It does not change the completion time or the results.
- R11: Pops before completion return the previous tile's coefficients. A pop sampled on the completion edge still returns the previous tile's entry, and the next pop returns the new coefficient 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register offset |
| wdata | input | 16 | Write data (sample or command) |
| rdata | output | 16 | Read data, valid one cycle after the read |

## Verification
Two things can happen in the same cycle: the engine stores its last coefficient and swaps result banks, and the host reads the pop register. The bench counts clock edges from the accepted start and places a pop read exactly on the completion edge. It expects that read to return the previous tile's second coefficient, and the very next pop to return the new tile's coefficient 0. Status reads one cycle before and one cycle after that edge check the exact busy window. A start issued mid-transform confirms that the window does not move.

// File: rtl/fdct_pkg.sv
package fdct_pkg;
    localparam int N        = 8;
    localparam int BLK      = N * N;
    localparam int IDX_W    = $clog2(BLK);
    localparam int AX_W     = $clog2(N);
    localparam int PIX_W    = 16;
    localparam int ACC_W    = 32;
    localparam int FRAC     = 6;
    localparam int COS_W    = 8;
    localparam int K_W      = 16;
    localparam int PROD_W   = ACC_W + K_W;
    localparam int SCALE_SH = 3 * FRAC;

    localparam logic [1:0] REG_PUSH = 2'd0;
    localparam logic [1:0] REG_POP  = 2'd1;
    localparam logic [1:0] REG_CMD  = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_COL, ST_SCL} eng_st_e;

    typedef logic signed [COS_W-1:0] cos_t;
    typedef logic signed [K_W-1:0]   kfac_t;

    typedef struct packed {
        logic                    we;
        logic [IDX_W-1:0]        idx;
        logic signed [PIX_W-1:0] data;
    } coef_wr_t;

    // first quarter-wave of the weights, angle k*pi/16 for k = 0..8
    function automatic cos_t quarter_wave(input int k);
        case (k)
            0:       return 8'sd64;
            1:       return 8'sd62;
            2:       return 8'sd59;
            3:       return 8'sd53;
            4:       return 8'sd45;
            5:       return 8'sd35;
            6:       return 8'sd24;
            7:       return 8'sd12;
            default: return 8'sd0;
        endcase
    endfunction

    // weight for sample index pos and frequency freq, folded onto the quarter wave
    function automatic cos_t cos_q6(input int pos, input int freq);
        int k;
        k = ((2 * pos + 1) * freq) % 32;
        if (k <= 8)       return quarter_wave(k);
        else if (k <= 16) return -quarter_wave(16 - k);
        else if (k <= 24) return -quarter_wave(k - 16);
        else              return quarter_wave(32 - k);
    endfunction

    // combined quarter and normalisation factor for output (u,v)
    function automatic kfac_t scale_k(input int u, input int v);
        int cu;
        int cv;
        cu = (u == 0) ? 45 : 64;
        cv = (v == 0) ? 45 : 64;
        return K_W'(((16 * cu) >>> FRAC) * cv);
    endfunction
endpackage

// File: rtl/fdct_inbuf.sv
module fdct_inbuf
    import fdct_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push,
    input  logic                        clr_idx,
    input  logic [PIX_W-1:0]            pix,
    output logic [BLK-1:0][PIX_W-1:0]   blk
);
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            blk <= '0;
        end else if (clr_idx) begin
            idx <= '0;
        end else if (push) begin
            blk[idx] <= pix << FRAC;
            idx      <= idx + 1'b1;
        end
    end

    // R3
    push_idx_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_idx |=> (idx == '0));
    // R3
    push_idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !clr_idx) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/fdct_engine.sv
module fdct_engine
    import fdct_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        go,
    input  logic [BLK-1:0][PIX_W-1:0]   blk,
    output logic                        busy,
    output logic                        done,
    output coef_wr_t                    wr
);
    eng_st_e                  st;
    logic [IDX_W-1:0]         oi;
    logic [AX_W-1:0]          xi, ji;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  psum [N];

    logic [AX_W-1:0]          u_i, v_i;
    logic [PIX_W-1:0]         px;
    cos_t                     w;
    logic signed [ACC_W-1:0]  mul_a;
    logic signed [K_W-1:0]    mul_b;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  term, sum;

    assign u_i = oi[IDX_W-1 -: AX_W];
    assign v_i = oi[AX_W-1:0];
    assign px  = blk[{xi, ji}];

    // operand selection for the single shared multiplier
    always_comb begin
        w     = '0;
        mul_a = '0;
        mul_b = '0;
        case (st)
            ST_ROW: begin
                w     = cos_q6(int'(ji), int'(v_i));
                mul_a = {{(ACC_W-PIX_W){px[PIX_W-1]}}, px};
                mul_b = {{(K_W-COS_W){w[COS_W-1]}}, w};
            end
            ST_COL: begin
                w     = cos_q6(int'(xi), int'(u_i));
                mul_a = psum[xi];
                mul_b = {{(K_W-COS_W){w[COS_W-1]}}, w};
            end
            ST_SCL: begin
                mul_a = acc;
                mul_b = scale_k(int'(u_i), int'(v_i));
            end
            default: ;
        endcase
        prod = {{K_W{mul_a[ACC_W-1]}}, mul_a} * {{ACC_W{mul_b[K_W-1]}}, mul_b};
        term = ACC_W'(prod >>> FRAC);
        sum  = acc + term;
    end

    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_SCL) && (oi == IDX_W'(BLK - 1));
    assign wr.we    = (st == ST_SCL);
    assign wr.idx   = oi;
    assign wr.data  = PIX_W'(prod >>> SCALE_SH);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            oi  <= '0;
            xi  <= '0;
            ji  <= '0;
            acc <= '0;
            for (int i = 0; i < N; i++) psum[i] <= '0;
        end else begin
            case (st)
                ST_IDLE: if (go) begin
                    st  <= ST_ROW;
                    oi  <= '0;
                    xi  <= '0;
                    ji  <= '0;
                    acc <= '0;
                end
                ST_ROW: begin
                    ji <= ji + 1'b1;
                    if (ji == AX_W'(N - 1)) begin
                        psum[xi] <= sum;
                        acc      <= '0;
                        xi       <= xi + 1'b1;
                        if (xi == AX_W'(N - 1)) st <= ST_COL;
                    end else begin
                        acc <= sum;
                    end
                end
                ST_COL: begin
                    acc <= sum;
                    xi  <= xi + 1'b1;
                    if (xi == AX_W'(N - 1)) st <= ST_SCL;
                end
                default: begin
                    acc <= '0;
                    oi  <= oi + 1'b1;
                    st  <= done ? ST_IDLE : ST_ROW;
                end
            endcase
        end
    end

    // R10
    restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_ROW || st == ST_COL) && go) |=> (oi == $past(oi)));
    // R7
    phase_order_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_COL && xi == AX_W'(N - 1)) |=> (st == ST_SCL));
endmodule

// File: rtl/fdct_outbuf.sv
module fdct_outbuf
    import fdct_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  coef_wr_t           wr,
    input  logic               done,
    input  logic               pop,
    output logic [PIX_W-1:0]   pop_word
);
    logic [1:0][BLK-1:0][PIX_W-1:0] bank;
    logic                           sel;
    logic [IDX_W-1:0]               pidx;

    assign pop_word = bank[sel][pidx];

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= '0;
            sel  <= 1'b0;
            pidx <= '0;
        end else begin
            if (wr.we) bank[~sel][wr.idx] <= wr.data;
            if (done)  sel <= ~sel;
            if (done)      pidx <= '0;
            else if (pop)  pidx <= pidx + 1'b1;
        end
    end

    // R9
    pop_idx_reset_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (pidx == '0));
    // R11
    bank_swap_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (sel != $past(sel)));
endmodule

// File: rtl/fdct_cop.sv
module fdct_cop
    import fdct_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         addr,
    input  logic [PIX_W-1:0]   wdata,
    output logic [PIX_W-1:0]   rdata
);
    logic                       push, go, accept, pop, busy, done;
    logic [BLK-1:0][PIX_W-1:0]  blk;
    logic [PIX_W-1:0]           pop_word;
    coef_wr_t                   cwr;

    assign push   = wr_en && (addr == REG_PUSH);
    assign go     = wr_en && (addr == REG_CMD) && (wdata == PIX_W'(1));
    assign accept = go && !busy;
    assign pop    = rd_en && (addr == REG_POP);

    fdct_inbuf u_in (
        .clk(clk), .rst(rst), .push(push), .clr_idx(accept),
        .pix(wdata), .blk(blk)
    );

    fdct_engine u_eng (
        .clk(clk), .rst(rst), .go(go), .blk(blk),
        .busy(busy), .done(done), .wr(cwr)
    );

    fdct_outbuf u_out (
        .clk(clk), .rst(rst), .wr(cwr), .done(done),
        .pop(pop), .pop_word(pop_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                REG_POP:  rdata <= pop_word;
                REG_STAT: rdata <= {{(PIX_W-1){1'b0}}, ~busy};
                default:  rdata <= '0;
            endcase
        end
    end

    // R5
    stat_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == REG_STAT && busy) |=> (rdata[0] == 1'b0));
endmodule

// File: tb/tb_fdct_cop.sv
module tb_fdct_cop;
    localparam int NONE = -100000;
    localparam int NPAT = 8;
    localparam int BUSY_CYC = 73 * 64;
    // kind, a, b, expected DC (NONE = take it from the model only)
    localparam int PAT [NPAT][4] = '{
        '{0,   10,    0,   77},
        '{0,  -10,    0,  -78},
        '{0,  127,    0,  982},
        '{0, -128,    0, -990},
        '{1,  -60,    3, NONE},
        '{2,  100, -100, NONE},
        '{3,    5,   -7, NONE},
        '{4, 12345,   0, NONE}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    int cyc = 0;
    int errors = 0, checks = 0;
    int pix [64];
    int expc [64];
    int prevc [64];
    int cw [8][8];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fdct_cop dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output int d);
        logic signed [15:0] t;
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        t = rdata;
        d = int'(t);
    endtask

    task automatic at_edge(input int t);
        while (cyc < t - 1) @(negedge clk);
    endtask

    function automatic int cfac(input int h);
        return (h == 0) ? 45 : 64;
    endfunction

    // independent model of R3, R6, R7, R8
    function automatic void model();
        for (int n = 0; n < 64; n++) begin
            int u, v, r, k;
            longint pr;
            logic signed [15:0] t;
            u = n / 8; v = n % 8; r = 0;
            for (int x = 0; x < 8; x++) begin
                int s;
                s = 0;
                for (int j = 0; j < 8; j++) begin
                    int img;
                    t = 16'(pix[x*8+j] << 6);
                    img = int'(t);
                    s += (img * cw[j][v]) >>> 6;
                end
                r += (s * cw[x][u]) >>> 6;
            end
            k  = ((16 * cfac(u)) >> 6) * cfac(v);
            pr = longint'(r) * longint'(k);
            t  = 16'(pr >>> 18);
            expc[n] = int'(t);
        end
    endfunction

    task automatic fill(input int kind, input int a, input int b);
        logic [31:0] st;
        st = 32'(a);
        for (int i = 0; i < 64; i++) begin
            case (kind)
                0: pix[i] = a;
                1: pix[i] = a + b * i;
                2: pix[i] = (((i / 8) + (i % 8)) % 2 == 1) ? b : a;
                3: pix[i] = a * ((i % 8) - 4) + b * (i / 8);
                default: begin
                    st = st * 32'd1103515245 + 32'd12345;
                    pix[i] = int'((st >> 16) & 32'hff) - 128;
                end
            endcase
        end
    endtask

    task automatic push_all();
        for (int i = 0; i < 64; i++) bus_wr(2'd0, 16'(pix[i]));
    endtask

    task automatic wait_ready();
        int d, n;
        n = 0;
        d = 0;
        while (d[0] == 1'b0 && n < 6000) begin
            bus_rd(2'd3, d);
            n++;
        end
        if (n >= 6000) check("R5 ready timeout", d, 1);
    endtask

    task automatic pop_all(input string tag);
        int d;
        for (int n = 0; n < 64; n++) begin
            bus_rd(2'd1, d);
            check(tag, d, expc[n]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R5 watchdog expired actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int d, s;
        for (int j = 0; j < 8; j++)
            for (int f = 0; f < 8; f++)
                cw[j][f] = $rtoi(64.0 * $cos(3.14159265358979 * real'((2*j+1)*f) / 16.0));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_rd(2'd3, d); check("R1 status after reset", d, 1);
        bus_rd(2'd1, d); check("R1 pop after reset", d, 0);

        // R4 command values other than 1 do not start
        bus_wr(2'd2, 16'd2);
        bus_rd(2'd3, d); check("R4 cmd=2 ignored", d, 1);
        bus_wr(2'd2, 16'd3);
        bus_rd(2'd3, d); check("R4 cmd=3 ignored", d, 1);

        // vector table walk: R2 R6 R7 R8 R9
        for (int e = 0; e < NPAT; e++) begin
            fill(PAT[e][0], PAT[e][1], PAT[e][2]);
            model();
            push_all();
            bus_wr(2'd2, 16'd1);
            wait_ready();
            for (int n = 0; n < 64; n++) begin
                bus_rd(2'd1, d);
                check("R2/R6/R7/R8/R9 coefficient", d, expc[n]);
                if (n == 0 && PAT[e][3] != NONE) check("R8 DC value", d, PAT[e][3]);
            end
            prevc = expc;
        end

        // R3 push index wraps after 64: six extra pushes overwrite slots 0..5
        fill(4, 777, 0);
        push_all();
        for (int k = 0; k < 6; k++) begin
            pix[k] = 7 * k - 20;
            bus_wr(2'd0, 16'(pix[k]));
        end
        model();
        bus_wr(2'd2, 16'd1);
        wait_ready();
        pop_all("R3 wrapped push");
        prevc = expc;

        // collision test: R5 R10 R11, and R3 index cleared by the accepted start
        fill(1, 3, -2);
        model();
        push_all();
        bus_wr(2'd2, 16'd1);
        s = cyc;
        at_edge(s + 1);           bus_rd(2'd3, d); check("R5 busy right after start", d, 0);
        at_edge(s + 2);           bus_rd(2'd1, d); check("R11 pop during busy", d, prevc[0]);
        at_edge(s + 100);         bus_wr(2'd2, 16'd1);
        at_edge(s + BUSY_CYC - 1); bus_rd(2'd3, d); check("R5 busy before completion", d, 0);
        at_edge(s + BUSY_CYC);     bus_rd(2'd1, d); check("R11 pop on completion edge", d, prevc[1]);
        at_edge(s + BUSY_CYC + 1); bus_rd(2'd3, d); check("R5/R10 ready after completion", d, 1);
        pop_all("R9/R10/R11 new block after completion");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule